// File: doc/BRIEF.md
# Serial EEPROM Word Read Controller

This controller fetches one 16-bit word from a three-wire serial EEPROM. A host presents a word address together with a one-cycle start strobe. The controller then drives the pins through a fixed sequence. First it lowers the protect-enable line and brings the part into select. Next it clocks out an 11-bit read command, most significant bit first, and clocks 16 data bits back in. Last it deselects the part and returns the pins to rest. When the word is complete it pulses a done strobe, and the word stays on the result output until the next read finishes.

Every pin step waits for one tick of an internal divider, and that tick fires once every `HALF_DIV` system clocks. A complete read therefore lasts a fixed 61 ticks. A parameter selects the addressing mode. In 8-bit mode the whole address byte goes into the command. In 6-bit mode the two upper address bits are sent as zero.

Top module: `mw_rd_master`

## Requirements
- R1: After reset, and whenever no read is in progress, the outputs rest as follows: sel_o=0, sclk_o=1, sdo_o=0, prot_o=1, busy_o=0, done_o=0.
- R2: A start_i pulse seen while idle begins a read, and busy_o rises on the next cycle. done_o is a single-cycle pulse, and busy_o falls in the same cycle that done_o is high.
- R3: A start_i pulse that arrives while busy_o is high has no effect. The read in progress still uses its original address, and no second read follows.
- R4: In 8-bit mode, the command is sampled on the sclk_o rising edges while sel_o is high, starting at the first edge with sdo_o=1. It is 11 bits, MSB first: 1, 1, 0, then addr_i[7:0] MSB first.
- R5: With ADDR_W=6 the command is 1, 1, 0, 0, 0, then addr_i[5:0] MSB first, so addr_i[7:6] have no effect on the command or the result.
- R6: Entry order: prot_o and sclk_o are already low when sel_o rises, and sdo_o is low at that moment.
- R7: Once the last command bit has been clocked, sdo_o is held low through the whole data phase and deselect.
- R8: A read gives 28 rising sclk_o edges while sel_o is high. Sixteen of them carry data, and sdi_i is captured one tick after each data edge, MSB first. The result appears on word_o with done_o and is held until the next done_o.
- R9: Exit order: sclk_o falls, then sel_o falls while prot_o is still low, then prot_o rises while sel_o is low, then sclk_o rises.
- R10: Pins change only on a divider tick, and a read keeps busy_o high for exactly 61*HALF_DIV cycles.
- R11: prot_o is low on every cycle in which sel_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | 8 | Word address, sampled with start_i |
| busy_o | output | 1 | High while a read is in progress |
| done_o | output | 1 | One-cycle pulse when word_o is updated |
| word_o | output | 16 | Last word read |
| sel_o | output | 1 | EEPROM chip select, active high |
| sclk_o | output | 1 | EEPROM serial clock, rests high |
| sdo_o | output | 1 | Command data to the EEPROM |
| sdi_i | input | 1 | Read data from the EEPROM |
| prot_o | output | 1 | Protect-enable line, low during a read |

## Verification
The bench models the EEPROM. The model detects the start bit, captures the frame, and drives a word derived from the address one bit per rising edge. An all-ones address catches a frame that is misaligned by one position or that includes the parked-clock edge as a bit. A start pulse injected in the middle of a read checks that a controller which re-latches the address, or re-arms itself, fails: it would return the wrong word or assert busy again after done. A pin monitor flags any select change made while the clock is high or protect is raised, and the exact busy length catches a sequence with a step added or missing. The 6-bit instance uses addresses with the upper bits set, so it fails if those bits reach the frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int CMD_LEN  = 11;
    localparam int DATA_LEN = 16;
    localparam int ADDR_IN  = 8;
    localparam int CNT_W    = $clog2(DATA_LEN);
    // start bit followed by the two read opcode bits
    localparam logic [2:0] RD_OP = 3'b110;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PREP, ST_SEL, ST_CLKUP,
        ST_CMD_LO, ST_CMD_HI, ST_CMD_END,
        ST_DAT_HI, ST_DAT_SMP,
        ST_DES_SEL, ST_DES_PROT, ST_DES_CLK
    } mw_state_e;

    typedef struct packed {
        mw_state_e            st;
        logic                 sel;
        logic                 sclk;
        logic                 sdo;
        logic                 prot;
        logic                 busy;
        logic                 done;
        logic [CMD_LEN-1:0]   frame;
        logic [CNT_W-1:0]     bcnt;
        logic [DATA_LEN-1:0]  acc;
        logic [DATA_LEN-1:0]  word;
    } mw_regs_t;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_cmd_frame.sv
module mw_cmd_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_IN-1:0] addr_i,
    output logic [CMD_LEN-1:0] frame_o
);
    generate
        if (ADDR_W == 6) begin : g_a6
            localparam logic [ADDR_IN-1:0] MASK = 8'h3F;
            assign frame_o = {RD_OP, addr_i & MASK};
        end else begin : g_a8
            assign frame_o = {RD_OP, addr_i};
        end
    endgenerate
endmodule

// File: rtl/mw_rd_master.sv
module mw_rd_master
    import mw_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_IN-1:0]  addr_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_LEN-1:0] word_o,
    output logic                sel_o,
    output logic                sclk_o,
    output logic                sdo_o,
    input  logic                sdi_i,
    output logic                prot_o
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_LEN - 1);
    localparam mw_regs_t RST = '{
        st: ST_IDLE, sel: 1'b0, sclk: 1'b1, sdo: 1'b0, prot: 1'b1,
        busy: 1'b0, done: 1'b0, frame: '0, bcnt: '0, acc: '0, word: '0};

    mw_regs_t d, q;
    logic tick_w;
    logic [CMD_LEN-1:0] frame_w;

    mw_tick_gen #(.DIV(HALF_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .run_i(q.busy), .tick_o(tick_w));

    mw_cmd_frame #(.ADDR_W(ADDR_W)) i_frame (
        .addr_i(addr_i), .frame_o(frame_w));

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (q.st == ST_IDLE) begin
            if (start_i) begin
                d.frame = frame_w;
                d.busy  = 1'b1;
                d.st    = ST_PREP;
            end
        end else if (tick_w) begin
            case (q.st)
                ST_PREP: begin
                    d.sdo = 1'b0; d.sclk = 1'b0; d.prot = 1'b0;
                    d.st = ST_SEL;
                end
                ST_SEL: begin
                    d.sel = 1'b1; d.st = ST_CLKUP;
                end
                ST_CLKUP: begin
                    d.sclk = 1'b1; d.bcnt = '0; d.st = ST_CMD_LO;
                end
                ST_CMD_LO: begin
                    d.sdo = q.frame[CMD_LEN-1]; d.sclk = 1'b0;
                    d.st = ST_CMD_HI;
                end
                ST_CMD_HI: begin
                    d.sclk  = 1'b1;
                    d.frame = {q.frame[CMD_LEN-2:0], 1'b0};
                    if (q.bcnt == CMD_LAST) begin
                        d.bcnt = '0; d.st = ST_CMD_END;
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1); d.st = ST_CMD_LO;
                    end
                end
                ST_CMD_END: begin
                    d.sdo = 1'b0; d.sclk = 1'b0; d.st = ST_DAT_HI;
                end
                ST_DAT_HI: begin
                    d.sclk = 1'b1; d.st = ST_DAT_SMP;
                end
                ST_DAT_SMP: begin
                    d.acc  = {q.acc[DATA_LEN-2:0], sdi_i};
                    d.sclk = 1'b0;
                    if (q.bcnt == DATA_LAST) begin
                        d.st = ST_DES_SEL;
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1); d.st = ST_DAT_HI;
                    end
                end
                ST_DES_SEL: begin
                    d.sel = 1'b0; d.st = ST_DES_PROT;
                end
                ST_DES_PROT: begin
                    d.prot = 1'b1; d.st = ST_DES_CLK;
                end
                ST_DES_CLK: begin
                    d.sclk = 1'b1; d.busy = 1'b0; d.done = 1'b1;
                    d.word = q.acc; d.st = ST_IDLE;
                end
                default: d = RST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign word_o = q.word;
    assign sel_o  = q.sel;
    assign sclk_o = q.sclk;
    assign sdo_o  = q.sdo;
    assign prot_o = q.prot;

    // R1
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sclk_o && !sel_o && prot_o && !sdo_o));
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R6
    sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> (!sclk_o && !prot_o && !sdo_o));
    // R9
    sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_o) |-> (!sclk_o && !prot_o));
    // R7
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {ST_DAT_HI, ST_DAT_SMP, ST_DES_SEL, ST_DES_PROT, ST_DES_CLK})
        |-> !sdo_o);
    // R10
    pin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sel_o, sclk_o, sdo_o, prot_o}) |-> $past(tick_w));
    // R11
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> !prot_o);
endmodule

// File: tb/test_mw_rd_master.sv
`timescale 1ns/1ps

function automatic logic [15:0] mw_content(input logic [7:0] a);
    return {a ^ 8'h5A, ~a ^ 8'h0F};
endfunction

module mw_model (
    input  logic        sel,
    input  logic        sclk,
    input  logic        sdo,
    output logic        sdi,
    output logic [10:0] cap,
    output int          sdo_err
);
    int ph, k;
    logic [15:0] w;
    initial begin ph = 0; k = 0; sdi = 1'b0; cap = '0; sdo_err = 0; w = '0; end
    always @(posedge sclk or negedge sel) begin
        if (!sel) begin
            ph = 0; k = 0;
        end else begin
            case (ph)
                0: if (sdo) begin cap = 11'd1; k = 1; ph = 1; end
                1: begin
                    cap = {cap[9:0], sdo}; k++;
                    if (k == 11) begin w = mw_content(cap[7:0]); k = 0; ph = 2; end
                end
                2: begin
                    if (sdo) sdo_err++;
                    sdi = w[15-k]; k++;
                    if (k == 16) ph = 3;
                end
                default: ;
            endcase
        end
    end
endmodule

module test_mw_rd_master;
    localparam int DIV8 = 4;
    localparam int DIV6 = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start8 = 1'b0, start6 = 1'b0;
    logic [7:0] addr8 = '0, addr6 = '0;
    logic busy8, done8, sel8, sclk8, sdo8, sdi8, prot8;
    logic busy6, done6, sel6, sclk6, sdo6, sdi6, prot6;
    logic [15:0] word8, word6;
    logic [10:0] cap8, cap6;
    int sdo_err8, sdo_err6;
    int total = 0, fails = 0;
    int seq_err = 0, rise_cnt = 0;
    logic p_sel = 1'b0, p_sclk = 1'b1, p_prot = 1'b1;

    always #2.5 clk = ~clk;

    mw_rd_master #(.HALF_DIV(DIV8), .ADDR_W(8)) i_mw_rd_master (
        .clk(clk), .rst_n(rst_n), .start_i(start8), .addr_i(addr8),
        .busy_o(busy8), .done_o(done8), .word_o(word8), .sel_o(sel8),
        .sclk_o(sclk8), .sdo_o(sdo8), .sdi_i(sdi8), .prot_o(prot8));
    mw_model i_m8 (.sel(sel8), .sclk(sclk8), .sdo(sdo8), .sdi(sdi8),
        .cap(cap8), .sdo_err(sdo_err8));

    mw_rd_master #(.HALF_DIV(DIV6), .ADDR_W(6)) i_mw_rd_master_a6 (
        .clk(clk), .rst_n(rst_n), .start_i(start6), .addr_i(addr6),
        .busy_o(busy6), .done_o(done6), .word_o(word6), .sel_o(sel6),
        .sclk_o(sclk6), .sdo_o(sdo6), .sdi_i(sdi6), .prot_o(prot6));
    mw_model i_m6 (.sel(sel6), .sclk(sclk6), .sdo(sdo6), .sdi(sdi6),
        .cap(cap6), .sdo_err(sdo_err6));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // pin-order monitor on the 8-bit instance (R6 R9 R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (sel8 && prot8) seq_err++;
            if (sel8 && !p_sel && (sclk8 || prot8)) seq_err++;
            if (!sel8 && p_sel && (sclk8 || prot8)) seq_err++;
            if (prot8 && !p_prot && sel8) seq_err++;
            if (sclk8 && !p_sclk && sel8) rise_cnt++;
            p_sel = sel8; p_sclk = sclk8; p_prot = prot8;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL R2 watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel8 == 0 && sel6 == 0, "R1", "sel idle", {sel8, sel6}, 0);
        chk(sclk8 == 1 && sclk6 == 1, "R1", "sclk idle", {sclk8, sclk6}, 3);
        chk(sdo8 == 0 && sdo6 == 0, "R1", "sdo idle", {sdo8, sdo6}, 0);
        chk(prot8 == 1 && prot6 == 1, "R1", "prot idle", {prot8, prot6}, 3);
        chk(busy8 == 0 && done8 == 0, "R1", "busy/done idle", {busy8, done8}, 0);
        chk(word8 == 0, "R1", "word reset", word8, 0);
    endtask

    // full read on the 8-bit instance; optionally a second start while busy
    task automatic t_read8(input logic [7:0] a, input bit inject, input logic [7:0] b);
        int n = 0;
        int s0 = seq_err, r0 = rise_cnt, e0 = sdo_err8;
        @(negedge clk); start8 = 1'b1; addr8 = a;
        @(negedge clk); start8 = 1'b0;
        chk(busy8 == 1, "R2", "busy after start", busy8, 1);
        while (!done8 && n < 5000) begin
            if (busy8) n++;
            if (inject && n == 100) begin start8 = 1'b1; addr8 = b; end
            else start8 = 1'b0;
            @(negedge clk);
        end
        start8 = 1'b0;
        chk(done8 && !busy8, "R2", "done with busy low", {done8, busy8}, 2);
        chk(word8 == mw_content(a), inject ? "R3" : "R8", "word", word8, mw_content(a));
        chk(cap8 == {3'b110, a}, inject ? "R3" : "R4", "frame", cap8, {3'b110, a});
        chk(n == 61 * DIV8, "R10", "busy cycles", n, 61 * DIV8);
        chk(rise_cnt - r0 == 28, "R8", "clock rises in select", rise_cnt - r0, 28);
        chk(seq_err == s0, "R6 R9 R11", "pin order violations", seq_err - s0, 0);
        chk(sdo_err8 == e0, "R7", "sdo high in data phase", sdo_err8 - e0, 0);
        @(negedge clk);
        chk(!done8, "R2", "done single pulse", done8, 0);
        if (inject) begin
            int extra = 0;
            repeat (20) begin
                @(negedge clk);
                if (busy8 || !sclk8 || sel8) extra++;
            end
            chk(extra == 0, "R3", "no second read", extra, 0);
        end
    endtask

    task automatic t_hold8();
        logic [15:0] w0 = word8;
        int pulses = 0;
        repeat (30) begin
            @(negedge clk);
            if (done8) pulses++;
        end
        chk(word8 == w0, "R8", "word held", word8, w0);
        chk(pulses == 0, "R2", "no spurious done", pulses, 0);
        chk(sclk8 && prot8 && !sel8, "R1", "rest after read", {sclk8, prot8, sel8}, 6);
    endtask

    task automatic t_read6(input logic [7:0] a);
        int n = 0;
        logic [7:0] m = a & 8'h3F;
        @(negedge clk); start6 = 1'b1; addr6 = a;
        @(negedge clk); start6 = 1'b0;
        while (!done6 && n < 5000) begin
            if (busy6) n++;
            @(negedge clk);
        end
        chk(done6 == 1, "R5", "done", done6, 1);
        chk(cap6 == {3'b110, 2'b00, m[5:0]}, "R5", "frame", cap6, {3'b110, 2'b00, m[5:0]});
        chk(word6 == mw_content(m), "R5", "word", word6, mw_content(m));
        chk(n == 61 * DIV6, "R10", "busy cycles 6-bit", n, 61 * DIV6);
        chk(sdo_err6 == 0, "R7", "sdo high in data phase 6-bit", sdo_err6, 0);
    endtask

    initial begin
        t_reset();
        t_read8(8'hFF, 1'b0, 8'h00);
        t_read8(8'h00, 1'b0, 8'h00);
        t_read8(8'h96, 1'b0, 8'h00);
        t_hold8();
        t_read8(8'h3C, 1'b1, 8'hC3);
        t_read6(8'hFF);
        t_read6(8'hC5);
        t_read6(8'h2A);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule